// File: doc/BRIEF.md
# Mute Ramp Controller with Interrupt Flags

This block sequences the soft mute of an audio output path and reports each finished transition through a small interrupt unit. It watches two mute controls, one for the DAC digital path and one for the headphone amplifier. Each change of a mute control starts a timed gain ramp. When the ramp finishes, the block sets a completion flag whose bit tells which channel finished and in which direction.

Jack insertion changes and short-circuit events are also recorded as flags. Software clears flags by writing ones. A mask register chooses which flags may raise the single interrupt line. The same register picks the line's polarity and whether the line is a level or a one-cycle pulse.

While the DAC is in standby, a change of its mute control is tracked but runs no ramp and raises no flag. A ramp that is already running when standby begins is cancelled. The gain arithmetic and the analog stages are not part of this block.

Top module: `mute_ramp_irq`

## Requirements
- R1: After reset, `flags_o` reads 0x00, `mask_o` reads 0x3F and `irq_o` is low.
- R2: When `dac_mute_i` rises, flag bit 0 (DAC gain-down done) sets `RAMP_LEN` clock edges after the edge that first samples the new level, and not one edge earlier.
- R3: When `dac_mute_i` falls, flag bit 1 (DAC gain-up done) sets after the same ramp length.
- R4: When `hp_mute_i` rises, flag bit 2 (headphone ramp-down done) sets after a ramp. When it falls, flag bit 3 (headphone ramp-up done) sets after a ramp.
- R5: While `dac_standby_i` is high, toggling `dac_mute_i` sets neither bit 0 nor bit 1, and no ramp runs on leaving standby.
- R6: A mute reversal during a running ramp restarts the ramp in the new direction. The ramp then takes a full `RAMP_LEN` edges, and only the final direction's flag is set.
- R7: A write with `flag_clr_we_i` high clears every flag in bits 5:0 whose `wdata_i` bit is 1. A 0 bit leaves its flag unchanged. Bit 6 is a status bit and cannot be cleared.
- R8: If a flag is set and cleared by a write in the same cycle, the set wins.
- R9: A write with `mask_we_i` high loads `mask_o` from `wdata_i`. A mask bit of 1 in bits 5:0 blocks the flag at the same position. With form 00 in mask bits 7:6, `irq_o` is high exactly when some unmasked flag in bits 5:0 is set.
- R10: Mask bits 7:6 select the interrupt form. 01 gives an active-low level. 10 gives a one-cycle high pulse when the unmasked pending state rises. 11 gives a one-cycle low pulse when it rises.
- R11: Flag bit 6 follows `jack_in_i` one edge later. Any change of `jack_in_i` sets bit 5 (jack event). `short_evt_i` high sets bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_mute_i | input | 1 | DAC digital mute control |
| hp_mute_i | input | 1 | Headphone mute control |
| dac_standby_i | input | 1 | DAC in standby; DAC ramps are suppressed |
| jack_in_i | input | 1 | Jack presence level |
| short_evt_i | input | 1 | Short-circuit event, sets flag bit 4 each cycle it is high |
| flag_clr_we_i | input | 1 | Write-one-to-clear strobe for the flag register |
| mask_we_i | input | 1 | Write strobe for the mask register |
| wdata_i | input | 8 | Write data for either strobe |
| flags_o | output | 8 | Flag register: bit 6 jack level, bits 5:0 latched flags, bit 7 zero |
| mask_o | output | 8 | Mask register: bits 7:6 interrupt form, bits 5:0 flag masks |
| irq_o | output | 1 | Interrupt line |

## Verification
The ramps are exercised with a single mute, a single unmute, a mute on each channel, a reversal partway through a ramp, and toggles during DAC standby. Together these separate correct direction decoding from correct timing and from proper suppression. Flag clearing is driven with masks that hit set bits, masks that miss them, and a clear that lands on the very edge a flag sets, which isolates the set-over-clear priority. The interrupt line is observed under all four form codes and with the relevant flag both masked and unmasked, so a level encoding can be told apart from a pulse encoding.

// File: rtl/mute_irq_pkg.sv
package mute_irq_pkg;
    localparam int NUM_FLAGS = 6;
    localparam int NUM_RAMPS = 2;
    localparam int FB_DAC_DOWN = 0;
    localparam int FB_DAC_UP   = 1;
    localparam int FB_HP_DOWN  = 2;
    localparam int FB_HP_UP    = 3;
    localparam int FB_SHORT    = 4;
    localparam int FB_JACK_EVT = 5;

    typedef enum logic [1:0] {
        IRQ_LEVEL_HI = 2'b00,
        IRQ_LEVEL_LO = 2'b01,
        IRQ_PULSE_HI = 2'b10,
        IRQ_PULSE_LO = 2'b11
    } irq_form_e;
endpackage

// File: rtl/mr_ramp_ctrl.sv
module mr_ramp_ctrl #(
    parameter int RAMP_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic mute_i,
    output logic done_up_o,
    output logic done_down_o
);
    localparam int CW = $clog2(RAMP_LEN + 1);

    typedef struct packed {
        logic          busy;
        logic          dir;
        logic          last;
        logic [CW-1:0] cnt;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        done_up_o   = 1'b0;
        done_down_o = 1'b0;
        st_d.last   = mute_i;
        if (!enable_i) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (mute_i != st_q.last) begin
            st_d.busy = 1'b1;
            st_d.dir  = mute_i;
            st_d.cnt  = CW'(RAMP_LEN - 1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                done_up_o   = !st_q.dir;
                done_down_o = st_q.dir;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a disabled channel never reports completion
    assert_no_done_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !(done_up_o || done_down_o));

    // R6: a down completion only appears while the control still asks for mute
    assert_down_matches_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_down_o |-> mute_i);

    assert_up_matches_unmute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_up_o |-> !mute_i);
endmodule

// File: rtl/mr_flag_unit.sv
module mr_flag_unit
    import mute_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 jack_i,
    input  logic                 clr_we_i,
    input  logic                 mask_we_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           flags_o,
    output logic [7:0]           mask_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic                 jack;
        logic [7:0]           mask;
        logic                 pend;
    } flag_st_t;

    flag_st_t             st_d, st_q;
    logic [NUM_FLAGS-1:0] ev;
    logic [NUM_FLAGS-1:0] clr;
    logic                 pend_now;
    irq_form_e            form;

    always_comb begin
        st_d             = st_q;
        ev               = set_i;
        ev[FB_JACK_EVT]  = set_i[FB_JACK_EVT] | (jack_i != st_q.jack);
        clr              = clr_we_i ? wdata_i[NUM_FLAGS-1:0] : '0;
        st_d.jack        = jack_i;
        st_d.flags       = (st_q.flags & ~clr) | ev;
        if (mask_we_i) st_d.mask = wdata_i;
        pend_now         = |(st_q.flags & ~st_q.mask[NUM_FLAGS-1:0]);
        st_d.pend        = pend_now;
        form             = irq_form_e'(st_q.mask[7:6]);
        unique case (form)
            IRQ_LEVEL_HI: irq_o = pend_now;
            IRQ_LEVEL_LO: irq_o = !pend_now;
            IRQ_PULSE_HI: irq_o = pend_now & !st_q.pend;
            IRQ_PULSE_LO: irq_o = !(pend_now & !st_q.pend);
            default:      irq_o = pend_now;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.jack  <= 1'b0;
            st_q.mask  <= 8'h3F;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = {1'b0, st_q.jack, st_q.flags};
    assign mask_o  = st_q.mask;

    for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_chk
        // R8: a set event always lands, even against a clearing write
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> flags_o[b]);
        if (b != FB_JACK_EVT) begin : g_w1c
            // R7: a one in the clear data removes an idle flag
            assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we_i && wdata_i[b] && !set_i[b]) |=> !flags_o[b]);
        end
    end

    // R10: the high pulse form lasts exactly one cycle
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o[7:6] == 2'b10 && irq_o && !mask_we_i) |=> !irq_o);
endmodule

// File: rtl/mute_ramp_irq.sv
module mute_ramp_irq
    import mute_irq_pkg::*;
#(
    parameter int RAMP_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dac_mute_i,
    input  logic       hp_mute_i,
    input  logic       dac_standby_i,
    input  logic       jack_in_i,
    input  logic       short_evt_i,
    input  logic       flag_clr_we_i,
    input  logic       mask_we_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] flags_o,
    output logic [7:0] mask_o,
    output logic       irq_o
);
    logic [NUM_RAMPS-1:0] ch_en;
    logic [NUM_RAMPS-1:0] ch_mute;
    logic [NUM_RAMPS-1:0] ch_up;
    logic [NUM_RAMPS-1:0] ch_down;
    logic [NUM_FLAGS-1:0] set_vec;

    // channel 0: DAC digital path, channel 1: headphone amplifier
    assign ch_en   = {1'b1, !dac_standby_i};
    assign ch_mute = {hp_mute_i, dac_mute_i};

    for (genvar c = 0; c < NUM_RAMPS; c++) begin : g_ramp
        mr_ramp_ctrl #(.RAMP_LEN(RAMP_LEN)) i_ramp (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable_i   (ch_en[c]),
            .mute_i     (ch_mute[c]),
            .done_up_o  (ch_up[c]),
            .done_down_o(ch_down[c])
        );
        assign set_vec[2*c]   = ch_down[c];
        assign set_vec[2*c+1] = ch_up[c];
    end

    assign set_vec[FB_SHORT]    = short_evt_i;
    assign set_vec[FB_JACK_EVT] = 1'b0;

    mr_flag_unit i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .jack_i   (jack_in_i),
        .clr_we_i (flag_clr_we_i),
        .mask_we_i(mask_we_i),
        .wdata_i  (wdata_i),
        .flags_o  (flags_o),
        .mask_o   (mask_o),
        .irq_o    (irq_o)
    );
endmodule

// File: tb/test_mute_ramp_irq.sv
module test_mute_ramp_irq;
    localparam int L = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dac_mute = 1'b0, hp_mute = 1'b0, dac_sb = 1'b0, jack = 1'b0, shorte = 1'b0;
    logic clr_we = 1'b0, mask_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] flags, mask;
    logic irq;

    always #4 clk = !clk;

    mute_ramp_irq #(.RAMP_LEN(L)) i_mute_ramp_irq (
        .clk(clk), .rst_n(rst_n), .dac_mute_i(dac_mute), .hp_mute_i(hp_mute),
        .dac_standby_i(dac_sb), .jack_in_i(jack), .short_evt_i(shorte),
        .flag_clr_we_i(clr_we), .mask_we_i(mask_we), .wdata_i(wdata),
        .flags_o(flags), .mask_o(mask), .irq_o(irq)
    );

    typedef struct {
        string      tag;
        logic [7:0] f;
        logic [7:0] m;
        logic       i;
    } exp_t;

    exp_t sb_q[$];
    int   outstanding = 0;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    // monitor: compares one expected item shortly after each edge
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (flags !== e.f || mask !== e.m || irq !== e.i) begin
                failures++;
                $display("FAIL %s: flags=%h mask=%h irq=%b expected flags=%h mask=%h irq=%b",
                         e.tag, flags, mask, irq, e.f, e.m, e.i);
            end
            outstanding--;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expect the given state after the next clock edge
    task automatic expect_next(input string tag, input logic [7:0] f,
                               input logic [7:0] m, input logic i);
        exp_t e;
        e.tag = tag; e.f = f; e.m = m; e.i = i;
        sb_q.push_back(e);
        outstanding++;
        wait (outstanding == 0);
        @(negedge clk);
        clr_we  = 1'b0;
        mask_we = 1'b0;
    endtask

    task automatic clear_flags(input string tag, input logic [7:0] v,
                               input logic [7:0] f, input logic [7:0] m, input logic i);
        clr_we = 1'b1; wdata = v;
        expect_next(tag, f, m, i);
    endtask

    task automatic write_mask(input string tag, input logic [7:0] v,
                              input logic [7:0] f, input logic i);
        mask_we = 1'b1; wdata = v;
        expect_next(tag, f, v, i);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_next("R1 reset", 8'h00, 8'h3F, 1'b0);

        // R2: mute ramps down, timing exact
        dac_mute = 1'b1;
        tick(L - 1);
        expect_next("R2 not early", 8'h00, 8'h3F, 1'b0);
        expect_next("R2 gain-down", 8'h01, 8'h3F, 1'b0);
        clear_flags("R7 clear bit0", 8'h01, 8'h00, 8'h3F, 1'b0);

        // R3: unmute ramps up
        dac_mute = 1'b0;
        tick(L);
        expect_next("R3 gain-up", 8'h02, 8'h3F, 1'b0);
        clear_flags("R7 zero bit untouched", 8'h01, 8'h02, 8'h3F, 1'b0);
        clear_flags("R7 clear bit1", 8'h02, 8'h00, 8'h3F, 1'b0);

        // R4: headphone both directions
        hp_mute = 1'b1;
        tick(L);
        expect_next("R4 hp ramp-down", 8'h04, 8'h3F, 1'b0);
        hp_mute = 1'b0;
        tick(L);
        expect_next("R4 hp ramp-up", 8'h0C, 8'h3F, 1'b0);
        clear_flags("R7 clear all", 8'h3F, 8'h00, 8'h3F, 1'b0);

        // R5: standby suppresses DAC ramps
        dac_sb = 1'b1;
        dac_mute = 1'b1;
        tick(L + 4);
        expect_next("R5 no flag on mute in standby", 8'h00, 8'h3F, 1'b0);
        dac_mute = 1'b0;
        tick(L + 4);
        expect_next("R5 no flag on unmute in standby", 8'h00, 8'h3F, 1'b0);
        dac_sb = 1'b0;
        tick(L + 4);
        expect_next("R5 no ramp after standby", 8'h00, 8'h3F, 1'b0);

        // R6: reversal restarts in the new direction
        dac_mute = 1'b1;
        tick(5);
        dac_mute = 1'b0;
        tick(L - 1);
        expect_next("R6 restarted not early", 8'h00, 8'h3F, 1'b0);
        expect_next("R6 final direction only", 8'h02, 8'h3F, 1'b0);
        clear_flags("R7 clear bit1 again", 8'h02, 8'h00, 8'h3F, 1'b0);

        // R8: clear on the completing edge loses
        dac_mute = 1'b1;
        tick(L);
        clr_we = 1'b1; wdata = 8'h01;
        expect_next("R8 set wins", 8'h01, 8'h3F, 1'b0);
        clear_flags("R7 clear after race", 8'h01, 8'h00, 8'h3F, 1'b0);

        // R11: jack and short events
        jack = 1'b1;
        expect_next("R11 jack status and event", 8'h60, 8'h3F, 1'b0);
        clear_flags("R7 status bit6 not cleared", 8'hFF, 8'h40, 8'h3F, 1'b0);
        shorte = 1'b1;
        expect_next("R11 short event", 8'h50, 8'h3F, 1'b0);
        shorte = 1'b0;

        // R9: masking with active-high level
        write_mask("R9 unmasked bit4 raises irq", 8'h2F, 8'h50, 1'b1);
        write_mask("R9 masked bit4 blocks irq", 8'h3F, 8'h50, 1'b0);

        // R10: other forms
        write_mask("R10 active-low pending", 8'h6F, 8'h50, 1'b0);
        write_mask("R10 active-low idle", 8'h7F, 8'h50, 1'b1);
        clear_flags("R7 clear short", 8'h10, 8'h40, 8'h7F, 1'b1);
        write_mask("R10 pulse form idle", 8'h80, 8'h40, 1'b0);
        shorte = 1'b1;
        expect_next("R10 high pulse", 8'h50, 8'h80, 1'b1);
        shorte = 1'b0;
        expect_next("R10 pulse ends", 8'h50, 8'h80, 1'b0);
        clear_flags("R7 clear short pulse", 8'h10, 8'h40, 8'h80, 1'b0);
        write_mask("R10 low pulse idle", 8'hC0, 8'h40, 1'b1);
        shorte = 1'b1;
        expect_next("R10 low pulse", 8'h50, 8'hC0, 1'b0);
        shorte = 1'b0;
        expect_next("R10 low pulse ends", 8'h50, 8'hC0, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule